// File: doc/BRIEF.md
# Vertical-Blanking Data Line Extractor

This block recovers data words that an upstream injector has placed on a few blanked lines of the vertical retrace interval of a video signal. An external analog slicer supplies horizontal sync, vertical sync and a thresholded data level, all synchronous to the system clock. The block counts line pulses after each frame pulse to find the lines that carry data. On each such line it waits a fixed offset, then samples the data level once per bit period, half a period after each bit boundary, so that every bit is taken near its centre.

Each data line carries one 16-bit word sent twice, most significant bit first. After the 32nd sample the block compares the two copies and offers the first copy to a downstream parallel-to-serial transmitter through a valid/ready handshake. A word that completes while the transmitter is busy is dropped and reported. A sync pulse that arrives before a word is complete throws the partial word away. The line offset, the bit-start offset and the bit-rate divider are parameters and must match the injector's settings.

Top module: `vbi_word_extractor`

## Requirements
- R1: While reset is held, and in the first cycle after reset, out_valid, overrun and mismatch_err are 0 and out_word is 0.
- R2: A sync rise is a clock edge at which the input is 1 and was 0 at the previous edge. A vsync rise sets the line number to 0. Each hsync rise adds 1, so the first hsync after vsync starts line 1. Only lines LINE_FIRST through LINE_FIRST+LINE_COUNT-1 produce a word. Other lines produce no output.
- R3: Take the edge at which a data line's hsync rise is detected as edge 0. Bit k (k = 0..31) is sampled at edge BIT_START+1+BIT_DIV/2+k*BIT_DIV. The data level at any other edge has no effect.
- R4: The first 16 bits sampled form the first copy, and the first bit sampled is its most significant bit. out_word carries the first copy whatever the second copy holds.
- R5: In the cycle after the edge that samples bit 31, if out_ready was 1 at that edge, out_valid is 1 for exactly one cycle and out_word holds the new word.
- R6: In that same completion cycle, mismatch_err is 1 when the two copies differ and 0 when they agree. This holds whether the word is delivered or dropped.
- R7: If out_ready was 0 at the completion edge, out_valid stays 0, overrun is 1 for one cycle, and out_word keeps its previous value.
- R8: A vsync rise during a line discards the partial word, so that line produces no output even if no further sync arrives. Line counting restarts from 0.
- R9: An hsync rise before bit 31 is sampled discards the partial word. Capture then starts fresh if the new line is a data line. Once a word completes, the rest of the line produces no further output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | input | 1 | Line sync pulse from the slicer, active high |
| vsync | input | 1 | Frame sync pulse from the slicer, active high |
| data_in | input | 1 | Thresholded data level |
| out_ready | input | 1 | Downstream transmitter can accept a word |
| out_valid | output | 1 | One-cycle strobe: out_word holds a new word |
| out_word | output | 16 | First copy of the recovered word |
| mismatch_err | output | 1 | The two copies of the completed word differ |
| overrun | output | 1 | A completed word was dropped because out_ready was 0 |

## Verification
Frames are driven with data on lines before, inside and after the data-line window, which separates correct line selection from an off-by-one in line counting. One frame inverts the level on the first and last cycle of every bit window, so only sampling at mid-bit recovers the words. Words whose two copies agree and words whose copies differ are both sent, with out_ready high and with it low, which separates delivery, dropping and the error flag. Frames also cut a line short with a vsync or with an early hsync, which shows whether partial words are discarded and whether line counting restarts.

// File: rtl/vbi_xtr_pkg.sv
// Shared types for the vertical-blanking data line extractor.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package vbi_xtr_pkg;

    // Capture state of the sequencer
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CAPT = 1'b1
    } xtr_state_t;

endpackage

// File: rtl/vbi_sync_sequencer.sv
// Sync sequencer: detects sync rises, counts lines after each frame sync
// and decides when a data line is being captured.
// Assumes: hsync and vsync are already synchronous to clk and last at
// least one cycle. When both rise at the same edge, vsync takes priority.
module vbi_sync_sequencer
    import vbi_xtr_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int LINE_FIRST = 10,
    parameter int LINE_COUNT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    input  logic vsync,
    input  logic word_done,
    output logic cap_start,
    output logic cap_en,
    output logic sync_evt
);
    localparam logic [LINE_W-1:0] L_MAX   = {LINE_W{1'b1}};
    localparam logic [LINE_W-1:0] L_FIRST = LINE_W'(LINE_FIRST);
    localparam logic [LINE_W-1:0] L_END   = LINE_W'(LINE_FIRST + LINE_COUNT);

    logic              hs_q, vs_q;
    logic              h_rise, v_rise;
    logic [LINE_W-1:0] line_q, line_nx;
    logic              is_data;
    xtr_state_t        state_q;

    // Edge detection and line-number lookahead
    always_comb begin
        h_rise  = hsync & ~hs_q;
        v_rise  = vsync & ~vs_q;
        line_nx = (line_q == L_MAX) ? line_q : line_q + 1'b1;
        is_data = (line_nx >= L_FIRST) && (line_nx < L_END);
    end

    assign cap_start = h_rise & ~v_rise & is_data;
    assign sync_evt  = h_rise | v_rise;
    assign cap_en    = (state_q == ST_CAPT);

    // Sync history, line counter and capture state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q    <= 1'b0;
            vs_q    <= 1'b0;
            line_q  <= '0;
            state_q <= ST_IDLE;
        end else begin
            hs_q <= hsync;
            vs_q <= vsync;
            if (v_rise) begin
                line_q  <= '0;
                state_q <= ST_IDLE;
            end else if (h_rise) begin
                line_q  <= line_nx;
                state_q <= is_data ? ST_CAPT : ST_IDLE;
            end else if (word_done) begin
                state_q <= ST_IDLE;
            end
        end
    end

endmodule

// File: rtl/vbi_bit_timer.sv
// Bit timer: after a start, waits BIT_START cycles and then runs a bit-rate
// divider. The sampling strobe fires half a bit period after each bit
// boundary.
// Assumes: BIT_DIV >= 2. The start pulse coincides with the hsync rise
// edge, and en stays high for the rest of the capture.
module vbi_bit_timer #(
    parameter int BIT_DIV   = 20,
    parameter int BIT_START = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic en,
    output logic sample_stb
);
    localparam int DLY_W = (BIT_START > 0) ? $clog2(BIT_START + 1) : 1;
    localparam int PH_W  = $clog2(BIT_DIV);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(BIT_DIV - 1);
    localparam logic [PH_W-1:0]  PH_HALF = PH_W'(BIT_DIV / 2);
    localparam logic [DLY_W-1:0] DLY_LD  = DLY_W'(BIT_START);

    logic [DLY_W-1:0] dly_q;
    logic [PH_W-1:0]  ph_q;

    // Strobe at mid-bit once the start offset has elapsed
    assign sample_stb = en && (dly_q == '0) && (ph_q == PH_HALF);

    // Start-offset countdown and bit-phase divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
            ph_q  <= '0;
        end else if (start) begin
            dly_q <= DLY_LD;
            ph_q  <= '0;
        end else if (en) begin
            if (dly_q != '0) begin
                dly_q <= dly_q - 1'b1;
            end else begin
                ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/vbi_word_capture.sv
// Word capture: shifts in the sampled bits, compares the two copies once
// both are in, and presents the first copy to the downstream stage.
// Assumes: start clears the bit count. sync_evt at the completion edge
// discards the word.
module vbi_word_capture #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sample_stb,
    input  logic              data_in,
    input  logic              sync_evt,
    input  logic              out_ready,
    output logic              word_done,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              mismatch_err,
    output logic              overrun
);
    localparam int TOT   = 2 * WORD_W;
    localparam int IDX_W = $clog2(TOT + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TOT - 1);

    logic [TOT-1:0]   sreg_q;
    logic [TOT-1:0]   full;
    logic [IDX_W-1:0] idx_q;

    // Complete word, including the bit being sampled now
    assign full      = {sreg_q[TOT-2:0], data_in};
    assign word_done = sample_stb && (idx_q == IDX_LAST);

    // Shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (start) begin
            idx_q <= '0;
        end else if (sample_stb) begin
            sreg_q <= full;
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Hand-off, drop and copy-compare outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            overrun      <= 1'b0;
            mismatch_err <= 1'b0;
            out_word     <= '0;
        end else begin
            out_valid    <= 1'b0;
            overrun      <= 1'b0;
            mismatch_err <= 1'b0;
            if (word_done && !sync_evt) begin
                out_valid    <= out_ready;
                overrun      <= ~out_ready;
                mismatch_err <= (full[TOT-1:WORD_W] != full[WORD_W-1:0]);
                if (out_ready) begin
                    out_word <= full[TOT-1:WORD_W];
                end
            end
        end
    end

endmodule

// File: rtl/vbi_word_extractor.sv
// Top level of the vertical-blanking data line extractor. Finds the data
// lines by counting syncs, samples each bit at mid-bit and delivers one
// word per data line.
// Assumes: line offset, bit-start offset and bit divider match the injector.
module vbi_word_extractor #(
    parameter int WORD_W     = 16,
    parameter int BIT_DIV    = 20,
    parameter int BIT_START  = 10,
    parameter int LINE_W     = 10,
    parameter int LINE_FIRST = 10,
    parameter int LINE_COUNT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              data_in,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              mismatch_err,
    output logic              overrun
);
    logic cap_start, cap_en, sync_evt, sample_stb, word_done;

    // Line counting and capture control
    vbi_sync_sequencer #(
        .LINE_W     (LINE_W),
        .LINE_FIRST (LINE_FIRST),
        .LINE_COUNT (LINE_COUNT)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .vsync     (vsync),
        .word_done (word_done),
        .cap_start (cap_start),
        .cap_en    (cap_en),
        .sync_evt  (sync_evt)
    );

    // Bit-rate divider with the half-period sampling strobe
    vbi_bit_timer #(
        .BIT_DIV   (BIT_DIV),
        .BIT_START (BIT_START)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cap_start),
        .en         (cap_en),
        .sample_stb (sample_stb)
    );

    // Bit assembly and word hand-off
    vbi_word_capture #(
        .WORD_W (WORD_W)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (cap_start),
        .sample_stb   (sample_stb),
        .data_in      (data_in),
        .sync_evt     (sync_evt),
        .out_ready    (out_ready),
        .word_done    (word_done),
        .out_valid    (out_valid),
        .out_word     (out_word),
        .mismatch_err (mismatch_err),
        .overrun      (overrun)
    );

endmodule

// File: rtl/vbi_word_extractor_chk.sv
// Checker for the extractor's port protocol, attached by bind.
// Assumes: the same clock and synchronous active-low reset as the top.
module vbi_word_extractor_chk (
    input logic clk,
    input logic rst_n,
    input logic hsync,
    input logic vsync,
    input logic out_ready,
    input logic out_valid,
    input logic overrun,
    input logic mismatch_err
);
    AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(out_ready)); // R5
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || overrun) |=> !(out_valid || overrun)); // R5
    AST_OVERRUN_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !$past(out_ready)); // R7
    AST_ERR_ON_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_err |-> (out_valid || overrun)); // R6
    AST_VSYNC_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |=> !(out_valid || overrun)); // R8
    AST_HSYNC_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |=> !(out_valid || overrun)); // R9
endmodule

bind vbi_word_extractor vbi_word_extractor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hsync        (hsync),
    .vsync        (vsync),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .overrun      (overrun),
    .mismatch_err (mismatch_err)
);

// File: tb/tb_vbi_word_extractor.sv
// Bench: behavioural per-cycle reference model plus directed frame checks.
module tb_vbi_word_extractor;
    localparam int WW = 16, DIV = 8, S = 4, LF = 3, LC = 2, HALF = DIV / 2;
    localparam int FULL_LEN = S + 1 + 2 * WW * DIV + 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic hsync = 1'b0, vsync = 1'b0, data_in = 1'b0, out_ready = 1'b1;
    logic out_valid, mismatch_err, overrun;
    logic [WW-1:0] out_word;

    int checks = 0, errors = 0;
    bit done = 1'b0, cmp_on = 1'b0;

    vbi_word_extractor #(.WORD_W(WW), .BIT_DIV(DIV), .BIT_START(S), .LINE_W(10),
        .LINE_FIRST(LF), .LINE_COUNT(LC)) dut (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .data_in(data_in),
        .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word),
        .mismatch_err(mismatch_err), .overrun(overrun));

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model state
    int m_line = 0, m_t = 0, m_n = 0;
    bit m_act = 1'b0;
    logic [31:0] m_bits = '0;
    logic hs_p = 1'b0, vs_p = 1'b0;
    logic e_valid = 1'b0, e_err = 1'b0, e_ovr = 1'b0;
    logic [WW-1:0] e_word = '0;

    // Model: evaluate the sampling with the old state, then the sync events
    always @(posedge clk) begin
        bit vr, hr;
        if (!rst_n) begin
            m_line = 0; m_act = 0; m_t = 0; m_n = 0; hs_p = 0; vs_p = 0;
            e_valid = 0; e_err = 0; e_ovr = 0; e_word = '0;
        end else begin
            vr = vsync && !vs_p;
            hr = hsync && !hs_p;
            e_valid = 0; e_err = 0; e_ovr = 0;
            if (m_act) begin
                m_t++;
                if (m_t == S + 1 + HALF + m_n * DIV) begin
                    m_bits = {m_bits[30:0], data_in};
                    m_n++;
                    if (m_n == 2 * WW) begin
                        m_act = 0;
                        if (!(vr || hr)) begin
                            e_err = (m_bits[31:16] != m_bits[15:0]);
                            if (out_ready) begin
                                e_valid = 1; e_word = m_bits[31:16];
                            end else begin
                                e_ovr = 1;
                            end
                        end
                    end
                end
            end
            if (vr) begin
                m_line = 0; m_act = 0;
            end else if (hr) begin
                m_line++;
                m_act = (m_line >= LF) && (m_line < LF + LC);
                m_t = 0; m_n = 0;
            end
            hs_p = hsync; vs_p = vsync;
        end
    end

    // Per-cycle comparison and collection of the delivered words
    logic [WW-1:0] got[$];
    int ovr_cnt = 0, err_cnt = 0;
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk(out_valid == e_valid, "R5", "out_valid", out_valid, e_valid);
            chk(out_word == e_word, "R4", "out_word", out_word, e_word);
            chk(mismatch_err == e_err, "R6", "mismatch_err", mismatch_err, e_err);
            chk(overrun == e_ovr, "R7", "overrun", overrun, e_ovr);
            if (out_valid) got.push_back(out_word);
            if (overrun) ovr_cnt++;
            if (mismatch_err) err_cnt++;
        end
    end

    task automatic clear_log();
        got.delete(); ovr_cnt = 0; err_cnt = 0;
    endtask

    task automatic pulse_vsync();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
    endtask

    // One line: hsync pulse, then len-1 cycles of data. With glitch set,
    // the first and last cycle of every bit window carry the inverted bit.
    task automatic send_line(input logic [31:0] bits, input bit glitch, input int len);
        @(negedge clk) begin hsync = 1'b1; data_in = 1'b0; end
        @(negedge clk) hsync = 1'b0;
        for (int t = 1; t < len; t++) begin
            if (t < S + 1) data_in = t[0];
            else begin
                int k, off;
                k = (t - S - 1) / DIV;
                off = (t - S - 1) % DIV;
                if (k > 31) data_in = t[1];
                else begin
                    data_in = bits[31 - k];
                    if (glitch && (off == 0 || off == DIV - 1)) data_in = ~data_in;
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            data_in = i[2];
            @(negedge clk);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && overrun == 0 && mismatch_err == 0, "R1", "flags in reset",
            {out_valid, overrun, mismatch_err}, 0);
        chk(out_word == 0, "R1", "out_word in reset", out_word, 0);
        @(negedge clk) rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && overrun == 0 && mismatch_err == 0, "R1", "flags after reset",
            {out_valid, overrun, mismatch_err}, 0);

        // R2: data only on lines LF..LF+LC-1, plus R4/R6 first copy on mismatch
        clear_log();
        pulse_vsync();
        send_line(32'hFFFF_FFFF, 0, FULL_LEN);
        send_line(32'h1234_1234, 0, FULL_LEN);
        send_line({16'hA5C3, 16'hA5C3}, 0, FULL_LEN);
        send_line({16'h0F0F, 16'h0F1F}, 0, FULL_LEN);
        send_line(32'hDEAD_DEAD, 0, FULL_LEN);
        chk(got.size() == 2, "R2", "words in window", got.size(), 2);
        if (got.size() == 2) begin
            chk(got[0] == 16'hA5C3, "R4", "word line 3", got[0], 16'hA5C3);
            chk(got[1] == 16'h0F0F, "R4", "first copy kept", got[1], 16'h0F0F);
        end
        chk(err_cnt == 1, "R6", "mismatch count", err_cnt, 1);

        // R3: glitches at bit edges are ignored by mid-bit sampling
        clear_log();
        pulse_vsync();
        send_line(32'h5555_5555, 1, FULL_LEN);
        send_line(32'hAAAA_AAAA, 1, FULL_LEN);
        send_line({16'h3C96, 16'h3C96}, 1, FULL_LEN);
        send_line({16'h8001, 16'h8001}, 1, FULL_LEN);
        chk(got.size() == 2, "R3", "words with glitches", got.size(), 2);
        if (got.size() == 2) begin
            chk(got[0] == 16'h3C96, "R3", "glitch word 1", got[0], 16'h3C96);
            chk(got[1] == 16'h8001, "R3", "glitch word 2", got[1], 16'h8001);
        end
        chk(err_cnt == 0, "R6", "no mismatch on equal copies", err_cnt, 0);

        // R7: not ready at completion drops the word
        clear_log();
        pulse_vsync();
        send_line(32'h0, 0, FULL_LEN);
        send_line(32'h0, 0, FULL_LEN);
        out_ready = 1'b0;
        send_line({16'h7E7E, 16'h7E7E}, 0, FULL_LEN);
        chk(ovr_cnt == 1, "R7", "overrun count", ovr_cnt, 1);
        chk(got.size() == 0, "R7", "dropped word not delivered", got.size(), 0);
        chk(out_word == 16'h8001, "R7", "out_word held", out_word, 16'h8001);
        out_ready = 1'b1;
        send_line({16'h1111, 16'h1111}, 0, FULL_LEN);
        chk(got.size() == 1 && got[0] == 16'h1111, "R5", "word after overrun",
            got.size() > 0 ? got[0] : 0, 16'h1111);

        // R8: vsync mid-line discards the partial word and restarts counting
        clear_log();
        pulse_vsync();
        send_line(32'h0, 0, FULL_LEN);
        send_line(32'h0, 0, FULL_LEN);
        send_line({16'h6666, 16'h6666}, 0, 150);
        pulse_vsync();
        idle(400);
        chk(got.size() == 0 && ovr_cnt == 0, "R8", "no output after vsync abort",
            got.size() + ovr_cnt, 0);
        send_line({16'h9999, 16'h9999}, 0, FULL_LEN);
        send_line({16'h4444, 16'h4444}, 0, FULL_LEN);
        chk(got.size() == 0, "R8", "lines 1-2 after restart ignored", got.size(), 0);
        send_line({16'h2468, 16'h2468}, 0, FULL_LEN);
        send_line({16'h1357, 16'h1357}, 0, FULL_LEN);
        chk(got.size() == 2, "R8", "words after restart", got.size(), 2);

        // R9: early hsync discards the partial word, next line starts fresh
        clear_log();
        pulse_vsync();
        send_line(32'h0, 0, FULL_LEN);
        send_line(32'h0, 0, FULL_LEN);
        send_line({16'hCAFE, 16'hCAFE}, 0, 150);
        send_line({16'hBEEF, 16'hBEEF}, 0, FULL_LEN);
        send_line({16'hFACE, 16'hFACE}, 0, FULL_LEN);
        chk(got.size() == 1, "R9", "one word after short line", got.size(), 1);
        if (got.size() == 1) chk(got[0] == 16'hBEEF, "R9", "fresh word", got[0], 16'hBEEF);

        idle(20);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule